// File: doc/BRIEF.md
# Buffered Streaming Flash Programming Sequencer

This block is the host-side engine for a flash device's streaming program mode. Software hands it a start word address, a word count and a stream of 16-bit data words. The sequencer checks the request, writes the setup and confirm commands, and waits a fixed settling delay. It then uses plain read cycles to poll the device status until the write buffer is free. From there it pushes the data in fixed 32-word fills. Each fill is followed by a wait until the device reports that the buffer has been committed to the array. After the last commit it makes one final status read, then ends the run with a one-cycle done pulse, an error flag and a 3-bit cause code.

The data input is a valid/ready stream. The sequencer raises `s_ready` only while it is writing a fill and stream words are still owed. A word is taken on a cycle where `s_valid` and `s_ready` are both high. If the source holds `s_valid` low, the current fill stalls: no bus write happens that cycle and the sequencer waits for the source. Once the requested count is used up, the rest of the fill is padded with 0xFFFF and no handshake takes place. Control inputs and result outputs are plain level or pulse signals.

The device side is a simple synchronous bus. `bus_wr` or `bus_rd` is asserted for one cycle per transfer. Read data on `bus_rdata` is sampled in the cycle after `bus_rd`. The sequencer never writes a status-read command, because in this mode any write is loaded as buffer data.

Top module: `bprog_seq`

## Requirements
- R1: A request is rejected when any of these holds: the start address has nonzero bits [4:0]; the word count is 0; or the start offset within the block (address bits [BLK_AW-1:0]) plus the count exceeds 2**BLK_AW. A rejected request gives a done pulse with err=1 and err_code=3'b100, and issues no bus cycle.
- R2: An accepted request first writes CMD_SETUP (default 16'h0080) and then CMD_CONF (default 16'h00D0), both to the start address, on two consecutive cycles.
- R3: For SETUP_DLY cycles after the confirm write, there is no bus cycle. All status is then obtained with plain reads only.
- R4: A status read in which SR[4]=1 ends the run at once, with no further writes. This applies both after setup and at the final check. It gives err=1 and err_code = {SR[4]&~SR[3]&~SR[1], SR[3], SR[1]}: bit0 means lock, bit1 means voltage, bit2 means other.
- R5: The first fill starts only after a setup status read with SR[4]=0, SR[7]=0 and SR[0]=0. Any other setup status value leads to another read.
- R6: Every fill is exactly 32 writes. Write k of the run (counted from 0 after the confirm) goes to start address + k. Its data is stream word k while k < count, and 0xFFFF otherwise.
- R7: After the 32nd write of a fill, no write occurs until a status read returns SR[0]=0.
- R8: `s_ready` is high only while a fill is in progress and stream words remain. A word is consumed exactly when `s_valid` and `s_ready` are both high. Exactly `count` words are consumed per accepted run.
- R9: After the last commit, one final status read decides the result: SR[4]=0 gives err=0 and err_code=0. `done` is a single-cycle pulse, and `err` and `err_code` change only together with `done`.
- R10: `busy` is high from the cycle after an accepted start until `done`, and is low in the cycle where `done` is high. `start` is ignored while busy. After reset, busy, done, err, s_ready, bus_wr and bus_rd are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; sampled only when idle |
| start_addr | input | AW | First word address of the run |
| word_count | input | BLK_AW+1 | Number of stream words to program |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Result of the last run: 1 = failed |
| err_code | output | 3 | Cause: bit0 lock, bit1 voltage, bit2 other/alignment |
| s_valid | input | 1 | Stream word available |
| s_data | input | DW | Stream word |
| s_ready | output | 1 | Sequencer accepts a stream word |
| bus_wr | output | 1 | Device write strobe |
| bus_rd | output | 1 | Device read strobe |
| bus_addr | output | AW | Device word address |
| bus_wdata | output | DW | Device write data |
| bus_rdata | input | DW | Device read data, valid the cycle after bus_rd |

## Verification
Counts of 1, 32 and 33 words separate the cases of padding a partial fill, an exactly full fill, and a second fill that is almost entirely padding. A run that ends on the last word of a block, and one that is one word longer, mark the block-crossing limit. Setup status values with SR[1], SR[3], both, or neither beside SR[4] tell the cause decoding apart. Setup reads that show only SR[7] or only SR[0] check that a fill cannot start early. A device model with random commit latency, a source with random valid gaps and random aligned requests then confirm the exact write list, the hold-off after each fill and the stream word count.

// File: rtl/bprog_pkg.sv
package bprog_pkg;

  localparam int unsigned BUF_AW    = 5;
  localparam int unsigned BUF_WORDS = 1 << BUF_AW;

  // status bit positions returned by the device
  localparam int unsigned SR_RDY  = 7;
  localparam int unsigned SR_FAIL = 4;
  localparam int unsigned SR_VOLT = 3;
  localparam int unsigned SR_LOCK = 1;
  localparam int unsigned SR_BUSY = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD_SETUP,
    ST_CMD_CONF,
    ST_DELAY,
    ST_POLL_RD,
    ST_POLL_CHK,
    ST_FILL
  } bp_state_e;

  typedef enum logic [1:0] {
    PK_SETUP,
    PK_COMMIT,
    PK_FINAL
  } bp_poll_e;

  typedef struct packed {
    logic other;
    logic volt;
    logic lock;
  } bp_cause_t;

  localparam bp_cause_t CAUSE_NONE  = '{other: 1'b0, volt: 1'b0, lock: 1'b0};
  localparam bp_cause_t CAUSE_OTHER = '{other: 1'b1, volt: 1'b0, lock: 1'b0};

endpackage

// File: rtl/bprog_req_check.sv
module bprog_req_check
  import bprog_pkg::*;
#(
  parameter int unsigned AW     = 24,
  parameter int unsigned BLK_AW = 10
) (
  input  logic [AW-1:0]   addr,
  input  logic [BLK_AW:0] count,
  output logic            ok
);
  localparam int unsigned SW = BLK_AW + 2;
  localparam logic [SW-1:0] BLK_WORDS = SW'(1) << BLK_AW;

  logic [SW-1:0] end_pos;
  logic          aligned;
  logic          nonzero;
  logic          unused_hi;

  assign end_pos   = SW'(addr[BLK_AW-1:0]) + SW'(count);
  assign aligned   = (addr[BUF_AW-1:0] == '0);
  assign nonzero   = (count != '0);
  assign ok        = aligned && nonzero && (end_pos <= BLK_WORDS);
  assign unused_hi = ^addr[AW-1:BLK_AW];

endmodule

// File: rtl/bprog_fill_ctr.sv
module bprog_fill_ctr
  import bprog_pkg::*;
#(
  parameter int unsigned AW     = 24,
  parameter int unsigned BLK_AW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   load_addr,
  input  logic [BLK_AW:0] load_count,
  input  logic            wr,
  input  logic            take,
  output logic [AW-1:0]   wr_addr,
  output logic            fill_last,
  output logic            words_left
);
  logic [BUF_AW-1:0] idx;
  logic [AW-1:0]     base;
  logic [BLK_AW:0]   rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      base <= '0;
      rem  <= '0;
    end else if (load) begin
      idx  <= '0;
      base <= load_addr;
      rem  <= load_count;
    end else begin
      if (wr) begin
        idx <= idx + 1'b1;
        if (idx == '1) base <= base + AW'(BUF_WORDS);
      end
      if (take) rem <= rem - 1'b1;
    end
  end

  assign wr_addr    = base + AW'(idx);
  assign fill_last  = (idx == '1);
  assign words_left = (rem != '0);

endmodule

// File: rtl/bprog_status_dec.sv
module bprog_status_dec
  import bprog_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] rdata,
  output logic          fail,
  output bp_cause_t     cause,
  output logic          buf_free,
  output logic          commit_clear
);
  logic unused_bits;

  assign fail         = rdata[SR_FAIL];
  assign cause.lock   = rdata[SR_LOCK];
  assign cause.volt   = rdata[SR_VOLT];
  assign cause.other  = rdata[SR_FAIL] & ~rdata[SR_LOCK] & ~rdata[SR_VOLT];
  assign buf_free     = ~rdata[SR_RDY] & ~rdata[SR_BUSY];
  assign commit_clear = ~rdata[SR_BUSY];
  assign unused_bits  = ^{rdata[DW-1:8], rdata[6:5], rdata[2]};

endmodule

// File: rtl/bprog_seq.sv
module bprog_seq
  import bprog_pkg::*;
#(
  parameter int unsigned AW          = 24,
  parameter int unsigned DW          = 16,
  parameter int unsigned BLK_AW      = 10,
  parameter int unsigned SETUP_DLY   = 16,
  parameter logic [15:0] CMD_SETUP   = 16'h0080,
  parameter logic [15:0] CMD_CONF    = 16'h00D0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  input  logic [BLK_AW:0] word_count,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [2:0]      err_code,
  input  logic            s_valid,
  input  logic [DW-1:0]   s_data,
  output logic            s_ready,
  output logic            bus_wr,
  output logic            bus_rd,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata
);
  localparam int unsigned DLYW = $clog2(SETUP_DLY + 1);
  localparam logic [DLYW-1:0] DLY_LAST = DLYW'(SETUP_DLY - 1);

  bp_state_e       st;
  bp_poll_e        kind;
  logic [DLYW-1:0] dly;
  logic [AW-1:0]   addr_q;
  logic            busy_q, done_q, err_q;
  bp_cause_t       code_q;

  logic            req_ok;
  logic            load;
  logic [AW-1:0]   fill_addr;
  logic            fill_last;
  logic            words_left;
  logic            take;
  logic            st_fail;
  bp_cause_t       st_cause;
  logic            st_free;
  logic            st_clear;

  bprog_req_check #(.AW(AW), .BLK_AW(BLK_AW)) u_req (
    .addr  (start_addr),
    .count (word_count),
    .ok    (req_ok)
  );

  bprog_fill_ctr #(.AW(AW), .BLK_AW(BLK_AW)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_addr  (start_addr),
    .load_count (word_count),
    .wr         (bus_wr && st == ST_FILL),
    .take       (take),
    .wr_addr    (fill_addr),
    .fill_last  (fill_last),
    .words_left (words_left)
  );

  bprog_status_dec #(.DW(DW)) u_stat (
    .rdata        (bus_rdata),
    .fail         (st_fail),
    .cause        (st_cause),
    .buf_free     (st_free),
    .commit_clear (st_clear)
  );

  assign load = (st == ST_IDLE) && start && req_ok;

  // bus and stream side, decoded from the state
  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = addr_q;
    bus_wdata = '0;
    s_ready   = 1'b0;
    unique case (st)
      ST_CMD_SETUP: begin
        bus_wr    = 1'b1;
        bus_wdata = DW'(CMD_SETUP);
      end
      ST_CMD_CONF: begin
        bus_wr    = 1'b1;
        bus_wdata = DW'(CMD_CONF);
      end
      ST_POLL_RD: bus_rd = 1'b1;
      ST_FILL: begin
        bus_addr  = fill_addr;
        s_ready   = words_left;
        bus_wr    = words_left ? s_valid : 1'b1;
        bus_wdata = words_left ? s_data : '1;
      end
      default: ;
    endcase
  end

  assign take = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      kind   <= PK_SETUP;
      dly    <= '0;
      addr_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= CAUSE_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (req_ok) begin
              addr_q <= start_addr;
              busy_q <= 1'b1;
              st     <= ST_CMD_SETUP;
            end else begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
              code_q <= CAUSE_OTHER;
            end
          end
        end
        ST_CMD_SETUP: st <= ST_CMD_CONF;
        ST_CMD_CONF: begin
          dly <= '0;
          st  <= ST_DELAY;
        end
        ST_DELAY: begin
          if (dly == DLY_LAST) begin
            kind <= PK_SETUP;
            st   <= ST_POLL_RD;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        ST_POLL_RD: st <= ST_POLL_CHK;
        ST_POLL_CHK: begin
          unique case (kind)
            PK_SETUP: begin
              if (st_fail) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                err_q  <= 1'b1;
                code_q <= st_cause;
                st     <= ST_IDLE;
              end else if (st_free) begin
                st <= ST_FILL;
              end else begin
                st <= ST_POLL_RD;
              end
            end
            PK_COMMIT: begin
              if (!st_clear) begin
                st <= ST_POLL_RD;
              end else if (words_left) begin
                st <= ST_FILL;
              end else begin
                kind <= PK_FINAL;
                st   <= ST_POLL_RD;
              end
            end
            default: begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              err_q  <= st_fail;
              code_q <= st_fail ? st_cause : CAUSE_NONE;
              st     <= ST_IDLE;
            end
          endcase
        end
        ST_FILL: begin
          if (bus_wr && fill_last) begin
            kind <= PK_COMMIT;
            st   <= ST_POLL_RD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign err_code = code_q;

endmodule

// File: rtl/bprog_seq_chk.sv
module bprog_seq_chk #(
  parameter int unsigned SETUP_DLY = 16
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic s_ready,
  input logic bus_wr,
  input logic bus_rd,
  input logic rd_bit0
);
  localparam int unsigned QW = $clog2(SETUP_DLY + 1);

  logic [15:0]   wcnt;
  logic [QW-1:0] qcnt;
  logic          hold;
  logic          rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      qcnt <= '0;
      hold <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      rd_q <= bus_rd;
      if (!busy) wcnt <= '0;
      else if (bus_wr) wcnt <= wcnt + 1'b1;
      if (busy && bus_wr && wcnt == 16'd1) qcnt <= QW'(SETUP_DLY);
      else if (qcnt != '0) qcnt <= qcnt - 1'b1;
      if (!busy) hold <= 1'b0;
      else if (bus_wr && wcnt >= 16'd33 && wcnt[4:0] == 5'd1) hold <= 1'b1;
      else if (rd_q && !rd_bit0) hold <= 1'b0;
    end
  end

  AST_QUIET_AFTER_CONF: assert property (@(posedge clk) disable iff (!rst_n)
    (qcnt != '0) |-> (!bus_wr && !bus_rd)); // R3
  AST_HOLD_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !bus_wr); // R7
  AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err) |-> done); // R9
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

endmodule

bind bprog_seq bprog_seq_chk #(.SETUP_DLY(SETUP_DLY)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .s_ready (s_ready),
  .bus_wr  (bus_wr),
  .bus_rd  (bus_rd),
  .rd_bit0 (bus_rdata[0])
);

// File: tb/tb_bprog_seq.sv
`timescale 1ns/1ps
module tb_bprog_seq;
  localparam int AW = 24, DW = 16, BLK_AW = 10, DLY = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [BLK_AW:0] word_count = '0;
  logic busy, done, err;
  logic [2:0] err_code;
  logic s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready;
  logic bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  bprog_seq #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW), .SETUP_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .busy(busy), .done(done), .err(err),
    .err_code(err_code), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0, errors = 0;

  // run configuration, written by the stimulus only
  logic clr = 1'b0;
  logic [7:0] cfg_setup_sr = 0, cfg_final_sr = 0;
  int cfg_wait = 0, cfg_total = 0, src_n = 0;
  logic [15:0] stream [0:127];

  // device model state, written by the model only
  logic [AW-1:0] log_a [0:255];
  logic [15:0]   log_d [0:255];
  int nw, fillw, busy_cnt, setup_wait, hold_viol, early_viol, src_idx, ready_viol;
  longint cyc = 0, conf_cyc, first_rd;

  always @(posedge clk) begin
    logic [7:0] sr;
    cyc++;
    if (clr) begin
      nw = 0; fillw = 0; busy_cnt = 0; setup_wait = cfg_wait;
      hold_viol = 0; early_viol = 0; src_idx = 0; conf_cyc = -1; first_rd = -1;
    end else begin
      if (s_valid && s_ready) src_idx++;
      if (busy_cnt > 0 && !bus_wr) busy_cnt--;
      if (bus_rd) begin
        if (first_rd < 0) first_rd = cyc;
        if (nw == 2) begin
          if (cfg_setup_sr != 0) sr = cfg_setup_sr;
          else if (setup_wait > 0) begin
            sr = (setup_wait % 2 == 1) ? 8'h81 : 8'h01;
            if (setup_wait % 3 == 0) sr = 8'h80;
            setup_wait--;
          end else sr = 8'h00;
        end else begin
          sr = (busy_cnt > 0) ? 8'h01 : 8'h00;
          if (nw == cfg_total && busy_cnt == 0) sr = sr | cfg_final_sr;
        end
        bus_rdata <= {8'($urandom), sr & 8'h9B};
      end
      if (bus_wr) begin
        if (busy_cnt > 0) hold_viol++;
        if (nw >= 2 && setup_wait > 0) early_viol++;
        if (nw < 256) begin log_a[nw] = bus_addr; log_d[nw] = bus_wdata; end
        nw++;
        if (nw == 2) conf_cyc = cyc;
        if (nw > 2) begin
          fillw++;
          if (fillw == 32) begin fillw = 0; busy_cnt = 1 + int'($urandom % 6); end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (clr) ready_viol = 0;
    else if (s_ready && src_idx >= src_n) ready_viol++;
    s_valid <= (src_idx < src_n) && ($urandom % 4 != 0);
    s_data  <= stream[src_idx % 128];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit req_valid(input logic [AW-1:0] a, input int n);
    return (a[4:0] == 0) && (n > 0) && (int'(a[BLK_AW-1:0]) + n <= (1 << BLK_AW));
  endfunction

  function automatic logic [2:0] cause_of(input logic [7:0] sr);
    return {sr[4] & ~sr[3] & ~sr[1], sr[3], sr[1]};
  endfunction

  task automatic run(input logic [AW-1:0] a, input int n, input logic [7:0] ssr,
                     input logic [7:0] fsr, input int sw, input bit poke, input string tag);
    bit v, exp_err;
    logic [2:0] exp_code;
    int total, t, bad, bad_k, consumed;
    logic [AW-1:0] ea;
    logic [15:0] ed;
    v = req_valid(a, n);
    total = !v ? 0 : (ssr[4] ? 2 : 2 + 32 * ((n + 31) / 32));
    consumed = (v && !ssr[4]) ? n : 0;
    if (!v) begin exp_err = 1; exp_code = 3'b100; end
    else if (ssr[4]) begin exp_err = 1; exp_code = cause_of(ssr); end
    else if (fsr[4]) begin exp_err = 1; exp_code = cause_of(fsr); end
    else begin exp_err = 0; exp_code = 3'b000; end
    for (int i = 0; i < 128; i++) stream[i] = 16'($urandom);
    @(negedge clk);
    cfg_setup_sr = ssr; cfg_final_sr = fsr; cfg_wait = sw; cfg_total = total;
    src_n = v ? n : 0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    start = 1'b1; start_addr = a; word_count = (BLK_AW+1)'(n);
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 20000) begin
      if (poke && t == 40) begin start = 1'b1; start_addr = a + 1; word_count = 1; end
      else start = 1'b0;
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    chk(t < 20000, "R9", {tag, " watchdog"}, t, 20000);
    chk(err == exp_err, v ? "R4" : "R1", {tag, " err"}, err, exp_err);
    chk(err_code == exp_code, v ? "R4" : "R1", {tag, " code"}, err_code, exp_code);
    chk(!busy, "R10", {tag, " busy at done"}, busy, 0);
    chk(nw == total, "R6", {tag, " write count"}, nw, total);
    bad = 0; bad_k = -1;
    for (int k = 0; k < total && k < nw; k++) begin
      if (k == 0) begin ea = a; ed = 16'h0080; end
      else if (k == 1) begin ea = a; ed = 16'h00D0; end
      else begin ea = a + AW'(k - 2); ed = (k - 2 < n) ? stream[k - 2] : 16'hFFFF; end
      if (log_a[k] !== ea || log_d[k] !== ed) begin
        if (bad == 0) bad_k = k;
        bad++;
      end
    end
    chk(bad == 0, (bad_k >= 0 && bad_k < 2) ? "R2" : "R6", {tag, " write list"}, bad_k, -1);
    chk(hold_viol == 0, "R7", {tag, " write before commit"}, hold_viol, 0);
    chk(early_viol == 0, "R5", {tag, " fill before free"}, early_viol, 0);
    chk(src_idx == consumed, "R8", {tag, " words taken"}, src_idx, consumed);
    chk(ready_viol == 0, "R8", {tag, " ready with no words"}, ready_viol, 0);
    if (v) chk(first_rd - conf_cyc > DLY, "R3", {tag, " poll delay"}, first_rd - conf_cyc, DLY + 1);
    @(negedge clk);
    chk(!done, "R9", {tag, " done width"}, done, 0);
  endtask

  initial begin
    #(5.0 * 195000);
    errors++;
    $display("FAIL watchdog global timeout actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !s_ready && !bus_wr && !bus_rd, "R10", "reset state",
        {busy, done, err, s_ready, bus_wr, bus_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 request rejection
    run(24'h000408, 10, 0, 0, 0, 0, "R1 unaligned");
    run(24'h000400, 0, 0, 0, 0, 0, "R1 zero count");
    run(24'h0007C0, 65, 0, 0, 0, 0, "R1 crosses block");
    // R4 setup failure causes
    run(24'h001000, 20, 8'h12, 0, 2, 0, "R4 lock");
    run(24'h001000, 20, 8'h18, 0, 0, 0, "R4 voltage");
    run(24'h001000, 20, 8'h10, 0, 1, 0, "R4 other");
    run(24'h001000, 20, 8'h1A, 0, 0, 0, "R4 lock+voltage");
    // R5 R6 fill sizes
    run(24'h002020, 32, 0, 0, 4, 0, "R6 exact fill");
    run(24'h002040, 1, 0, 0, 3, 0, "R6 single word");
    run(24'h002040, 33, 0, 0, 5, 0, "R6 one over");
    run(24'h0027C0, 64, 0, 0, 0, 0, "R1 block end");
    // R9 final check, R10 start ignored while busy
    run(24'h003000, 40, 0, 8'h12, 1, 0, "R9 final lock");
    run(24'h003100, 70, 0, 0, 2, 1, "R10 start while busy");
    for (int i = 0; i < 8; i++) begin
      int off, n;
      off = int'($urandom % 30);
      n = 1 + int'($urandom % 96);
      if (off * 32 + n > 1024) n = 1024 - off * 32;
      run(AW'(($urandom % 64) << BLK_AW) | AW'(off * 32), n, 0, 0,
          int'($urandom % 5), 0, "R6 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule